// File: doc/BRIEF.md
# Unrolled Tile Diffusion Stencil Unit

This unit performs one explicit time step of two-dimensional heat diffusion over a 3x3 tile of mesh points. Each result is a weighted five-point stencil: a horizontal weight scales the sum of the two neighbours along the first index, a vertical weight scales the sum of the two neighbours along the second index, and a self weight scales the point itself. The three weights are static configuration inputs. They are held constant while tiles stream through.

The 21 distinct values that a tile needs (a 5x5 window without its corners) arrive on two sequential 15-word input streams. Each stream has its own valid/ready handshake. Both streams fill one of two tile buffers, so the next tile can load while the current tile is being emitted. A sequencer walks the nine output points through one shared, purely feed-forward arithmetic path. It emits the nine results on one valid/ready output stream and flags the ninth result as last.

The sequencer has two states. `S_WAIT` holds until the buffer under read holds a complete tile. Transition `T_START` then moves to `S_EMIT` at point (0,0). In `S_EMIT`, each accepted result takes transition `T_STEP` to the next point. The accepted ninth result takes transition `T_DONE`, which releases the buffer and returns to `S_WAIT`.

Top module: `stencil_tile_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both input ready outputs are high and `out_valid` is low.
- R2: Data and weights are 16-bit two's-complement values with 8 fraction bits. Each result is the exact sum Kh*(W+E) + Kv*(N+S) + Kc*C. That sum has 16 fraction bits. It is rounded to 8 fraction bits by adding 128 and then arithmetic-shifting right by 8. The result saturates to 0x7FFF and 0x8000.
- R3: Port A word k (0..14) is the window value at first-index offset (k mod 5) - 1 and second-index offset (k div 5), both relative to the tile origin.
- R4: Port B words 0..2 are second-index offset -1 at first-index offsets 0..2. Words 12..14 are second-index offset +3 at first-index offsets 0..2. Words 3..11 are discarded and have no effect on any result.
- R5: Each tile yields exactly nine results in row-major order with the first index fastest. `out_last` is high on the ninth result only, and never on the first.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady.
- R7: Let the last input word of a tile be accepted at clock edge k while the unit is idle. Then `out_valid` is still low after edge k and is high after edge k+1. After the ninth result is accepted, `out_valid` is low for one cycle.
- R8: Tile buffers are double-buffered. A port's ready goes low only when both buffers already hold that port's 15 words for tiles not yet fully emitted. Both ports are ready in the cycle after the ninth result of a tile is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_h | input | 16 | Weight on the first-index neighbour pair |
| coef_v | input | 16 | Weight on the second-index neighbour pair |
| coef_c | input | 16 | Weight on the centre value |
| in_a_valid | input | 1 | Port A word valid |
| in_a_data | input | 16 | Port A word (middle three window rows) |
| in_a_ready | output | 1 | Port A may accept a word |
| in_b_valid | input | 1 | Port B word valid |
| in_b_data | input | 16 | Port B word (outer rows plus discarded words) |
| in_b_ready | output | 1 | Port B may accept a word |
| out_valid | output | 1 | Result valid |
| out_data | output | 16 | Stencil result |
| out_last | output | 1 | Ninth result of a tile |
| out_ready | input | 1 | Consumer accepts the result |

## Verification
The first result of a tile loaded into an idle unit is due one cycle after the edge that takes its final input word. The bench samples `out_valid` at the falling edges either side of that point. Later results are due one per accepted handshake, so the bench compares each accepted word at the falling edge before the accepting edge with the next value from its arithmetic model. It also confirms that the last flag lands on beat nine. Ready is sampled at the falling edge after the buffer-filling handshake, and again after the releasing handshake, to confirm the one-cycle reaction that R8 calls for.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
    localparam int DW   = 16;
    localparam int FRAC = 8;
    localparam int ACCW = 2 * DW + 3;

    typedef logic signed [DW-1:0]   word_t;
    typedef logic signed [ACCW-1:0] acc_t;

    localparam acc_t WMAX     = acc_t'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam acc_t WMIN     = -WMAX - acc_t'(1);
    localparam acc_t HALF_LSB = acc_t'(64'sd1 <<< (FRAC - 1));

    // Round half up to the word's fraction width, then clamp to the word range.
    function automatic word_t round_sat(input acc_t a);
        acc_t r;
        r = (a + HALF_LSB) >>> FRAC;
        if (r > WMAX)
            return word_t'(WMAX);
        else if (r < WMIN)
            return word_t'(WMIN);
        else
            return word_t'(r);
    endfunction
endpackage

// File: rtl/stencil_point.sv
module stencil_point
    import stencil_pkg::*;
(
    input  word_t k_horiz,
    input  word_t k_vert,
    input  word_t k_self,
    input  word_t west,
    input  word_t east,
    input  word_t north,
    input  word_t south,
    input  word_t centre,
    output word_t result
);
    localparam int SW = DW + 1;
    typedef logic signed [SW-1:0] pair_t;

    pair_t sum_h;
    pair_t sum_v;
    acc_t  acc;

    // Pure feed-forward: two pair sums, three products, one rounding stage.
    always_comb begin
        sum_h  = pair_t'(west) + pair_t'(east);
        sum_v  = pair_t'(north) + pair_t'(south);
        acc    = acc_t'(k_horiz) * acc_t'(sum_h)
               + acc_t'(k_vert)  * acc_t'(sum_v)
               + acc_t'(k_self)  * acc_t'(centre);
        result = round_sat(acc);
    end
endmodule

// File: rtl/stencil_capture.sv
module stencil_capture
    import stencil_pkg::*;
#(
    parameter  int TILE  = 3,
    localparam int ROW   = TILE + 2,
    localparam int NA    = TILE * ROW,
    localparam int NB    = 2 * TILE,
    localparam int NSKIP = NA - NB,
    localparam int CW    = $clog2(NA),
    localparam int BW    = $clog2(NB)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    input  word_t             a_data,
    output logic              a_ready,
    input  logic              b_valid,
    input  word_t             b_data,
    output logic              b_ready,
    input  logic              release_i,
    output logic              full_o,
    output word_t [NA-1:0]    win_a_o,
    output word_t [NB-1:0]    win_b_o
);
    localparam logic [CW-1:0] LAST    = CW'(NA - 1);
    localparam logic [CW-1:0] SKIP_LO = CW'(TILE);
    localparam logic [CW-1:0] SKIP_HI = CW'(TILE + NSKIP);

    word_t [1:0][NA-1:0] a_mem;
    word_t [1:0][NB-1:0] b_mem;
    logic  [1:0]         a_done;
    logic  [1:0]         b_done;
    logic                a_wp, b_wp, rd_p;
    logic  [CW-1:0]      a_cnt, b_cnt;
    logic                a_fire, b_fire, b_keep;
    logic  [BW-1:0]      b_slot;

    assign a_ready = !a_done[a_wp];
    assign b_ready = !b_done[b_wp];
    assign a_fire  = a_valid && a_ready;
    assign b_fire  = b_valid && b_ready;

    always_comb begin
        b_keep = (b_cnt < SKIP_LO) || (b_cnt >= SKIP_HI);
        b_slot = (b_cnt < SKIP_LO) ? BW'(b_cnt) : BW'(b_cnt - CW'(NSKIP));
    end

    always_ff @(posedge clk) begin
        if (a_fire)
            a_mem[a_wp][a_cnt] <= a_data;
        if (b_fire && b_keep)
            b_mem[b_wp][b_slot] <= b_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cnt <= '0;
            b_cnt <= '0;
            a_wp  <= 1'b0;
            b_wp  <= 1'b0;
        end else begin
            if (a_fire) begin
                if (a_cnt == LAST) begin
                    a_cnt <= '0;
                    a_wp  <= !a_wp;
                end else begin
                    a_cnt <= a_cnt + 1'b1;
                end
            end
            if (b_fire) begin
                if (b_cnt == LAST) begin
                    b_cnt <= '0;
                    b_wp  <= !b_wp;
                end else begin
                    b_cnt <= b_cnt + 1'b1;
                end
            end
        end
    end

    // A buffer under read is never the one a port is still filling,
    // so release and completion never touch the same flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_done <= '0;
            b_done <= '0;
            rd_p   <= 1'b0;
        end else begin
            if (release_i) begin
                a_done[rd_p] <= 1'b0;
                b_done[rd_p] <= 1'b0;
                rd_p         <= !rd_p;
            end
            if (a_fire && a_cnt == LAST)
                a_done[a_wp] <= 1'b1;
            if (b_fire && b_cnt == LAST)
                b_done[b_wp] <= 1'b1;
        end
    end

    assign full_o  = a_done[rd_p] && b_done[rd_p];
    assign win_a_o = a_mem[rd_p];
    assign win_b_o = b_mem[rd_p];

    // R8: freeing a buffer makes room on both ports at once.
    p_free_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> a_ready && b_ready);
endmodule

// File: rtl/stencil_tile_unit.sv
module stencil_tile_unit
    import stencil_pkg::*;
#(
    parameter  int TILE = 3,
    localparam int ROW  = TILE + 2,
    localparam int NA   = TILE * ROW,
    localparam int NB   = 2 * TILE,
    localparam int XW   = $clog2(TILE),
    localparam int AW   = $clog2(NA),
    localparam int BW   = $clog2(NB)
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] coef_h,
    input  logic signed [DW-1:0] coef_v,
    input  logic signed [DW-1:0] coef_c,
    input  logic                 in_a_valid,
    input  logic signed [DW-1:0] in_a_data,
    output logic                 in_a_ready,
    input  logic                 in_b_valid,
    input  logic signed [DW-1:0] in_b_data,
    output logic                 in_b_ready,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data,
    output logic                 out_last,
    input  logic                 out_ready
);
    localparam logic [XW-1:0] XMAX = XW'(TILE - 1);

    typedef enum logic {S_WAIT, S_EMIT} state_t;

    state_t          state, state_nx;
    logic [XW-1:0]   px, py, px_nx, py_nx;
    logic            tile_full, at_end, fire_out, release_buf;
    word_t [NA-1:0]  win_a;
    word_t [NB-1:0]  win_b;
    word_t           nb_w, nb_e, nb_n, nb_s, nb_c, point_res;
    int              nb_base;

    stencil_capture #(.TILE(TILE)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_valid   (in_a_valid),
        .a_data    (in_a_data),
        .a_ready   (in_a_ready),
        .b_valid   (in_b_valid),
        .b_data    (in_b_data),
        .b_ready   (in_b_ready),
        .release_i (release_buf),
        .full_o    (tile_full),
        .win_a_o   (win_a),
        .win_b_o   (win_b)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_WAIT;
            px    <= '0;
            py    <= '0;
        end else begin
            state <= state_nx;
            px    <= px_nx;
            py    <= py_nx;
        end
    end

    // Next state: T_START, T_STEP, T_DONE.
    always_comb begin
        state_nx = state;
        px_nx    = px;
        py_nx    = py;
        unique case (state)
            S_WAIT: begin
                if (tile_full) begin
                    state_nx = S_EMIT;
                    px_nx    = '0;
                    py_nx    = '0;
                end
            end
            S_EMIT: begin
                if (fire_out) begin
                    if (at_end) begin
                        state_nx = S_WAIT;
                    end else if (px == XMAX) begin
                        px_nx = '0;
                        py_nx = py + 1'b1;
                    end else begin
                        px_nx = px + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // Outputs.
    always_comb begin
        at_end      = (px == XMAX) && (py == XMAX);
        out_valid   = (state == S_EMIT);
        out_last    = out_valid && at_end;
        fire_out    = out_valid && out_ready;
        release_buf = fire_out && at_end;
        out_data    = point_res;
    end

    // Neighbourhood gather for the current point.
    always_comb begin
        nb_base = int'(py) * ROW + int'(px);
        nb_w    = win_a[AW'(nb_base)];
        nb_c    = win_a[AW'(nb_base + 1)];
        nb_e    = win_a[AW'(nb_base + 2)];
        nb_n    = (py == '0)  ? win_b[BW'(px)]
                              : win_a[AW'(nb_base + 1 - ROW)];
        nb_s    = (py == XMAX) ? win_b[BW'(int'(px) + TILE)]
                               : win_a[AW'(nb_base + 1 + ROW)];
    end

    stencil_point u_point (
        .k_horiz (coef_h),
        .k_vert  (coef_v),
        .k_self  (coef_c),
        .west    (nb_w),
        .east    (nb_e),
        .north   (nb_n),
        .south   (nb_s),
        .centre  (nb_c),
        .result  (point_res)
    );

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> in_a_ready && in_b_ready && !out_valid);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    p_first_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !out_last);

    p_gap_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);
endmodule

// File: tb/stencil_tile_unit_tb.sv
`timescale 1ns/1ps
module stencil_tile_unit_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n;
    logic signed [15:0] c0, c1, c2;
    logic               a_valid, b_valid, a_ready, b_ready;
    logic signed [15:0] a_data, b_data;
    logic               out_valid, out_last, out_ready;
    logic signed [15:0] out_data;

    stencil_tile_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .coef_h(c0), .coef_v(c1), .coef_c(c2),
        .in_a_valid(a_valid), .in_a_data(a_data), .in_a_ready(a_ready),
        .in_b_valid(b_valid), .in_b_data(b_data), .in_b_ready(b_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    int          exp_q[$];
    int          win[5][5];
    logic [15:0] sa[15];
    logic [15:0] sb[15];
    bit          cons_en = 0;
    bit          bp_mode = 0;
    bit          rdy, prev_stall, prev_last;
    logic [15:0] prev_data;
    int          beat = 0;
    int          ev;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model(int w, int e, int n, int s, int c);
        longint acc;
        acc = longint'(c0) * longint'(w + e) + longint'(c1) * longint'(n + s)
            + longint'(c2) * longint'(c);
        acc = (acc + 128) >>> 8;
        if (acc > 32767)  acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    // mode 0 random, 1 all max positive, 2 ramp pattern
    task automatic gen_tile(input int mode);
        for (int u = 0; u < 5; u++)
            for (int v = 0; v < 5; v++) begin
                logic [15:0] w16;
                if (mode == 1)      w16 = 16'h7fff;
                else if (mode == 2) w16 = 16'(u * 64 + v * 16);
                else                w16 = 16'($urandom);
                win[u][v] = int'($signed(w16));
            end
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 5; c++)
                sa[r * 5 + c] = 16'(win[c][r + 1]);
        for (int k = 3; k < 12; k++) sb[k] = 16'($urandom);
        for (int x = 0; x < 3; x++) begin
            sb[x]      = 16'(win[x + 1][0]);
            sb[12 + x] = 16'(win[x + 1][4]);
        end
        for (int y = 0; y < 3; y++)
            for (int x = 0; x < 3; x++)
                exp_q.push_back(model(win[x][y + 1], win[x + 2][y + 1],
                                      win[x + 1][y], win[x + 1][y + 2], win[x + 1][y + 1]));
    endtask

    task automatic push_a();
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            a_valid = 1'b1;
            a_data  = sa[k];
            while (!a_ready) @(negedge clk);
        end
        @(negedge clk);
        a_valid = 1'b0;
    endtask

    task automatic push_b();
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            b_valid = 1'b1;
            b_data  = sb[k];
            while (!b_ready) @(negedge clk);
        end
        @(negedge clk);
        b_valid = 1'b0;
    endtask

    task automatic send_tile();
        fork
            push_a();
            push_b();
        join
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || out_valid) @(negedge clk);
        @(negedge clk);
    endtask

    // Consumer: checks R2 R3 R4 data, R5 last flag, R6 hold.
    initial begin
        out_ready = 1'b0;
        prev_stall = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                rdy = cons_en && (!bp_mode || ($urandom_range(99) < 60));
                if (prev_stall)
                    chk(out_valid && out_data == prev_data && out_last == prev_last,
                        "R6 hold while stalled", int'(out_data), int'(prev_data));
                if (out_valid && rdy) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5 unexpected result", int'(out_data), 0);
                    end else begin
                        ev = exp_q.pop_front();
                        chk(int'(out_data) == ev, "R2 R3 R4 result", int'(out_data), ev);
                        chk(out_last == (beat == 8), "R5 last flag", int'(out_last),
                            int'(beat == 8));
                        beat = (beat + 1) % 9;
                    end
                end
                prev_stall = out_valid && !rdy;
                prev_data  = out_data;
                prev_last  = out_last;
                out_ready  = rdy;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] cv[6];
        cv = '{16'h8000, 16'hff00, 16'h0000, 16'h0080, 16'h0100, 16'h7fff};
        rst_n = 1'b0; a_valid = 1'b0; b_valid = 1'b0; a_data = '0; b_data = '0;
        c0 = 16'sh0040; c1 = 16'sh0040; c2 = 16'sh0080;
        repeat (3) @(negedge clk);
        chk(a_ready && b_ready && !out_valid, "R1 during reset",
            int'({a_ready, b_ready, out_valid}), 6);
        rst_n = 1'b1;
        @(negedge clk);
        chk(a_ready && b_ready && !out_valid, "R1 after reset",
            int'({a_ready, b_ready, out_valid}), 6);

        // R7: first result one cycle after the final input edge
        cons_en = 1'b1;
        gen_tile(2);
        send_tile();
        chk(!out_valid, "R7 not yet valid", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid, "R7 valid next cycle", int'(out_valid), 1);
        drain();

        // R2 saturation both ways
        c0 = 16'sh7fff; c1 = 16'sh7fff; c2 = 16'sh7fff;
        gen_tile(1); send_tile(); drain();
        c0 = -16'sh8000; c1 = -16'sh8000; c2 = -16'sh8000;
        gen_tile(1); send_tile(); drain();

        // R2 weight sweep with random windows
        foreach (cv[i])
            foreach (cv[j])
                foreach (cv[k]) begin
                    c0 = cv[i]; c1 = cv[j]; c2 = cv[k];
                    gen_tile(0); send_tile(); drain();
                end

        // R8: double buffering and ready behaviour
        c0 = 16'sh0060; c1 = -16'sh0020; c2 = 16'sh0100;
        cons_en = 1'b0;
        gen_tile(0); send_tile();
        chk(a_ready && b_ready, "R8 ready with one buffer free",
            int'({a_ready, b_ready}), 3);
        gen_tile(0); send_tile();
        chk(!a_ready && !b_ready, "R8 not ready with both buffers full",
            int'({a_ready, b_ready}), 0);
        chk(out_valid, "R8 first tile presented", int'(out_valid), 1);
        cons_en = 1'b1;
        while (exp_q.size() != 9) @(posedge clk);
        @(negedge clk);
        chk(a_ready && b_ready, "R8 ready after ninth result",
            int'({a_ready, b_ready}), 3);
        drain();

        // R6 and R5 under random back-pressure with back-to-back tiles
        bp_mode = 1'b1;
        repeat (40) begin
            gen_tile(0);
            send_tile();
        end
        drain();
        bp_mode = 1'b0;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule